// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. One of up to sixteen asynchronous candidate inputs is selected and brought through a two-stage synchronizer. A digital filter then only accepts a new level after it has been seen for a programmable run of consecutive clocks. An edge detector with selectable polarity turns level changes of the filtered signal into events. An event prescaler lets through every first, second, fourth or eighth event. Each surviving event copies the timer's free-running count into the capture register.

A capture flag records that a capture happened. An overcapture flag records that a further capture arrived while the capture flag was still set. Software clears each flag with a one-cycle write-one-to-clear pulse. Configuration is applied through plain level inputs. The counter that feeds the count bus, and any compare or output logic, sit outside this block.

Top module: `timer_capture_channel`

## Requirements
- R1: The 4-bit source index selects which bit of the candidate input bus feeds the channel; activity on every other candidate bit has no effect on the capture register or the flags.
- R2: The selected input passes through two synchronizing flops, then the filter stage, before edge detection.
- R3: With filter code 0 the filter passes every synchronized sample. With code k > 0 the filtered level changes only after 2·k consecutive synchronized samples differ from it, so shorter pulses are dropped.
- R4: Polarity code 00 makes rising edges of the filtered signal the capture event, 01 falling edges, and 10 or 11 both edges.
- R5: Prescaler code p (00, 01, 10, 11) captures on every 2^p-th qualifying event, that is every 1st, 2nd, 4th or 8th one.
- R6: The prescaler event count returns to zero whenever the enable is low or the prescaler code differs from its value on the previous clock.
- R7: Events are counted and captures occur only while the 2-bit mode input equals 01 (direct input); any other mode leaves the capture register and flags untouched.
- R8: No event is counted and no capture occurs while the enable input is low.
- R9: A capture stores the value on the count bus at the capture clock edge. If the selected input changes just before clock edge 0 and holds, with N = 1 for filter code 0 and N = 2·k otherwise, the register loads the count sampled at edge N+2 and shows it after that edge.
- R10: Every capture sets the capture flag in the same edge as the register load. A clear pulse on the capture-flag clear input clears it on the next edge, and a capture in that same edge wins.
- R11: A capture taken while the capture flag is set, as seen before that edge, also sets the overcapture flag. The overcapture clear pulse clears it unless a new overcapture arrives in the same edge.
- R12: After reset the capture register, both flags, the synchronizer, the filter and the prescaler count are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Free-running counter value |
| src_i | input | 16 | Candidate capture inputs, bit 0 is the device pin |
| cfg_sel_i | input | 4 | Index of the candidate input to use |
| cfg_mode_i | input | 2 | Channel mode, 01 enables the capture path |
| cfg_pol_i | input | 2 | Edge polarity: 00 rising, 01 falling, 1x both |
| cfg_filt_i | input | 4 | Filter code, 0 means no filtering |
| cfg_psc_i | input | 2 | Event prescaler code, divide by 2^code |
| cfg_en_i | input | 1 | Channel capture enable |
| clr_cap_i | input | 1 | Write-one-to-clear pulse for the capture flag |
| clr_ovr_i | input | 1 | Write-one-to-clear pulse for the overcapture flag |
| cap_val_o | output | 16 | Captured counter value |
| cap_flag_o | output | 1 | Capture flag |
| ovr_flag_o | output | 1 | Overcapture flag |

## Verification
The bench changes the selected input half a cycle before a clock edge and counts that edge as edge 0. The register, both flags and the stored count are due after edge N+2, where N is 1 for filter code 0 and 2·k otherwise. Each level is held for N+5 cycles before any output is read, so sampling always falls after that edge. Glitch pulses are held for fewer than N sampled edges and are followed by N+3 quiet cycles before the real edge, so the filter's run counter starts again from zero. Configuration and clear pulses take effect on the edge after they are driven, and the bench reads the affected outputs one cycle later.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        POL_RISE   = 2'b00,
        POL_FALL   = 2'b01,
        POL_BOTH_A = 2'b10,
        POL_BOTH_B = 2'b11
    } pol_e;

    localparam logic [1:0] MODE_DIRECT = 2'b01;

    // Number of consecutive differing samples needed before the filter moves
    function automatic logic [8:0] filt_need(input logic [7:0] code);
        if (code == 8'd0) begin
            return 9'd1;
        end
        return {code, 1'b0};
    endfunction

endpackage

// File: rtl/cap_input_cond.sv
module cap_input_cond #(
    parameter  int NSRC   = 16,
    parameter  int FILT_W = 4,
    localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int FCNT_W = FILT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [FILT_W-1:0] filt_code_i,
    output logic              sync_o,
    output logic              filt_o
);
    import cap_pkg::*;

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              filt;
        logic [FCNT_W-1:0] run;
    } cond_t;

    cond_t q, d;
    logic picked;
    logic [FCNT_W-1:0] need;
    logic [8:0] need_w;

    // Candidate input multiplexer
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel_i == SEL_W'(i)) begin
                picked = src_i[i];
            end
        end
    end

    assign need_w = filt_need(8'(filt_code_i));
    assign need   = FCNT_W'(need_w);

    always_comb begin
        d      = q;
        d.s1   = picked;
        d.s2   = q.s1;
        if (q.s2 == q.filt) begin
            d.run = '0;
        end else if ((q.run + 1'b1) >= need) begin
            d.filt = q.s2;
            d.run  = '0;
        end else begin
            d.run = q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sync_o = q.s2;
    assign filt_o = q.filt;

endmodule

// File: rtl/cap_event_gen.sv
module cap_event_gen #(
    parameter  int PSC_W  = 2,
    localparam int PCNT_W = (1 << PSC_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             filt_i,
    input  logic [1:0]       pol_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             en_i,
    input  logic             arm_i,
    output logic             fire_o
);
    import cap_pkg::*;

    typedef struct packed {
        logic              prev;
        logic [PSC_W-1:0]  psc_last;
        logic [PCNT_W-1:0] cnt;
    } evt_t;

    evt_t q, d;
    logic rise, fall, hit;
    logic [PCNT_W-1:0] limit;
    pol_e pol;

    assign pol   = pol_e'(pol_i);
    assign rise  = filt_i & ~q.prev;
    assign fall  = ~filt_i & q.prev;
    assign limit = PCNT_W'((1 << psc_i) - 1);

    always_comb begin
        case (pol)
            POL_RISE: hit = rise;
            POL_FALL: hit = fall;
            default:  hit = rise | fall;
        endcase
    end

    always_comb begin
        d          = q;
        d.prev     = filt_i;
        d.psc_last = psc_i;
        fire_o     = 1'b0;
        if (!en_i || (psc_i != q.psc_last)) begin
            d.cnt = '0;
        end else if (arm_i && hit) begin
            if (q.cnt >= limit) begin
                fire_o = 1'b1;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/timer_capture_channel.sv
module timer_capture_channel #(
    parameter  int CNT_W  = 16,
    parameter  int NSRC   = 16,
    parameter  int FILT_W = 4,
    parameter  int PSC_W  = 2,
    localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [NSRC-1:0]   src_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [1:0]        cfg_mode_i,
    input  logic [1:0]        cfg_pol_i,
    input  logic [FILT_W-1:0] cfg_filt_i,
    input  logic [PSC_W-1:0]  cfg_psc_i,
    input  logic              cfg_en_i,
    input  logic              clr_cap_i,
    input  logic              clr_ovr_i,
    output logic [CNT_W-1:0]  cap_val_o,
    output logic              cap_flag_o,
    output logic              ovr_flag_o
);
    import cap_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             cap;
        logic             ovr;
    } capst_t;

    capst_t q, d;
    logic sync_w, filt_w, fire_w, arm_w;

    assign arm_w = cfg_en_i && (cfg_mode_i == MODE_DIRECT);

    cap_input_cond #(
        .NSRC  (NSRC),
        .FILT_W(FILT_W)
    ) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .sel_i      (cfg_sel_i),
        .filt_code_i(cfg_filt_i),
        .sync_o     (sync_w),
        .filt_o     (filt_w)
    );

    cap_event_gen #(
        .PSC_W(PSC_W)
    ) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .filt_i(filt_w),
        .pol_i (cfg_pol_i),
        .psc_i (cfg_psc_i),
        .en_i  (cfg_en_i),
        .arm_i (arm_w),
        .fire_o(fire_w)
    );

    always_comb begin
        d = q;
        if (clr_cap_i) begin
            d.cap = 1'b0;
        end
        if (clr_ovr_i) begin
            d.ovr = 1'b0;
        end
        if (fire_w) begin
            d.val = cnt_i;
            d.cap = 1'b1;
            if (q.cap) begin
                d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cap_val_o  = q.val;
    assign cap_flag_o = q.cap;
    assign ovr_flag_o = q.ovr;

endmodule

// File: rtl/timer_capture_channel_chk.sv
module timer_capture_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_mode_i,
    input logic             cfg_en_i,
    input logic             sync_w,
    input logic             filt_w,
    input logic [CNT_W-1:0] cap_val_o,
    input logic             cap_flag_o,
    input logic             ovr_flag_o
);

    p_filt_from_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_w) |-> (filt_w == $past(sync_w)));

    p_hold_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode_i) != 2'b01) |-> $stable(cap_val_o));

    p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_en_i) |-> $stable(cap_val_o));

    p_load_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val_o) |-> cap_flag_o);

    p_ovr_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag_o) |-> $past(cap_flag_o));

endmodule

bind timer_capture_channel timer_capture_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode_i(cfg_mode_i),
    .cfg_en_i  (cfg_en_i),
    .sync_w    (sync_w),
    .filt_w    (filt_w),
    .cap_val_o (cap_val_o),
    .cap_flag_o(cap_flag_o),
    .ovr_flag_o(ovr_flag_o)
);

// File: tb/timer_capture_channel_test.sv
module timer_capture_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i;
    logic [15:0] src_i = '0;
    logic [3:0]  cfg_sel_i = '0;
    logic [1:0]  cfg_mode_i = 2'b01;
    logic [1:0]  cfg_pol_i = '0;
    logic [3:0]  cfg_filt_i = '0;
    logic [1:0]  cfg_psc_i = '0;
    logic        cfg_en_i = 1'b0;
    logic        clr_cap_i = 1'b0;
    logic        clr_ovr_i = 1'b0;
    logic [15:0] cap_val_o;
    logic        cap_flag_o, ovr_flag_o;

    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  lvl = 0;
    int  pc = 0;
    int  exp_val = 0;
    bit  exp_cf = 0, exp_of = 0;

    timer_capture_channel uut (.*);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign cnt_i = cyc[15:0];

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, int'(cap_val_o), exp_val);
        chk(tag, int'(cap_flag_o), int'(exp_cf));
        chk(tag, int'(ovr_flag_o), int'(exp_of));
    endtask

    function automatic int need_of(input int code);
        return (code == 0) ? 1 : 2 * code;
    endfunction

    // Other candidate inputs get random noise; the selected one carries lvl
    task automatic drive();
        logic [15:0] r;
        r = 16'($urandom);
        r[cfg_sel_i] = lvl;
        src_i = r;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drive();
        end
    endtask

    task automatic set_cfg(input int sel, input int filt, input int psc,
                           input int pol, input int mode, input bit en);
        @(negedge clk);
        if (!en || psc != int'(cfg_psc_i)) pc = 0;
        cfg_sel_i  = 4'(sel);
        cfg_filt_i = 4'(filt);
        cfg_psc_i  = 2'(psc);
        cfg_pol_i  = 2'(pol);
        cfg_mode_i = 2'(mode);
        cfg_en_i   = en;
        drive();
        step(2);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clr_cap_i = 1'b1;
        clr_ovr_i = 1'b1;
        drive();
        @(negedge clk);
        clr_cap_i = 1'b0;
        clr_ovr_i = 1'b0;
        drive();
        exp_cf = 0;
        exp_of = 0;
    endtask

    // Optional short glitch toward nl, then a real change to nl
    task automatic toggle(input bit nl, input int glitch);
        int n, t0;
        bit qual;
        n = need_of(int'(cfg_filt_i));
        if (glitch > 0) begin
            @(negedge clk);
            lvl = nl;
            drive();
            step(glitch - 1);
            lvl = ~nl;
            step(1);
            step(n + 3);
        end
        @(negedge clk);
        lvl = nl;
        drive();
        t0 = cyc;
        step(n + 5);
        qual = (cfg_pol_i == 2'b00) ? nl : (cfg_pol_i == 2'b01) ? !nl : 1'b1;
        if (qual && cfg_en_i && cfg_mode_i == 2'b01) begin
            pc++;
            if (pc == (1 << cfg_psc_i)) begin
                pc = 0;
                if (exp_cf) exp_of = 1;
                exp_cf = 1;
                exp_val = (t0 + n + 2) & 16'hFFFF;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", int'(cap_val_o), 0);
        chk("R12", int'(cap_flag_o), 0);
        chk("R12", int'(ovr_flag_o), 0);
        rst_n = 1'b1;
        step(2);

        // R7: mode other than 01 blocks captures
        set_cfg(0, 0, 0, 3, 0, 1);
        toggle(1, 0); toggle(0, 0);
        check_all("R7");
        set_cfg(0, 0, 0, 3, 2, 1);
        toggle(1, 0); toggle(0, 0);
        check_all("R7");

        // R8: disabled channel never captures
        set_cfg(0, 0, 0, 3, 1, 0);
        toggle(1, 0); toggle(0, 0);
        check_all("R8");

        // R2, R9, R10: direct rising capture with filter off
        set_cfg(0, 0, 0, 0, 1, 1);
        toggle(1, 0);
        check_all("R9");
        chk("R10", int'(cap_flag_o), 1);
        // R4: falling edge ignored with rising polarity
        toggle(0, 0);
        check_all("R4");
        // R11: second capture while flag set
        toggle(1, 0);
        check_all("R11");
        chk("R11", int'(ovr_flag_o), 1);
        // R10: clear pulses
        clear_flags();
        check_all("R10");
        // R4: falling polarity
        set_cfg(0, 0, 0, 1, 1, 1);
        toggle(0, 0);
        check_all("R4");
        chk("R4", int'(cap_flag_o), 1);
        clear_flags();

        // R3: filter code 2 needs 4 samples; 3-sample glitch dropped
        set_cfg(0, 2, 0, 0, 1, 1);
        toggle(1, 3);
        check_all("R3");
        toggle(0, 3);
        check_all("R3");
        clear_flags();

        // R1: noise on other inputs only, selected input quiet
        set_cfg(7, 0, 0, 3, 1, 1);
        step(40);
        check_all("R1");
        chk("R1", int'(cap_flag_o), 0);

        // R5, R6: divide by 2, counter reset on code change
        set_cfg(7, 0, 1, 3, 1, 1);
        toggle(~lvl, 0);
        check_all("R6");
        set_cfg(7, 0, 2, 3, 1, 1);
        set_cfg(7, 0, 1, 3, 1, 1);
        toggle(~lvl, 0);
        check_all("R6");
        chk("R6", int'(cap_flag_o), 0);
        toggle(~lvl, 0);
        check_all("R5");
        chk("R5", int'(cap_flag_o), 1);
        clear_flags();

        // Random trials: R1, R3, R4, R5, R9, R10, R11
        for (int t = 0; t < 24; t++) begin
            int fc;
            fc = $urandom_range(0, 3);
            set_cfg($urandom_range(0, 15), fc, $urandom_range(0, 3),
                    $urandom_range(0, 3), 1, 0);
            set_cfg(int'(cfg_sel_i), fc, int'(cfg_psc_i), int'(cfg_pol_i), 1, 1);
            if (t % 3 == 0) clear_flags();
            for (int s = 0; s < 10; s++) begin
                int n, g;
                n = need_of(fc);
                g = (n > 1) ? $urandom_range(0, n - 1) : 0;
                toggle(~lvl, g);
                check_all("R5");
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule